// File: doc/BRIEF.md
# Virtual-Channel and Switch Allocator

This block handles allocation for a single router output link that several virtual channels share. Each input virtual channel shows the allocator the flit at the front of its buffer as a valid bit, a head marker and a tail marker. Route computation has already chosen this output port for that flit.

Allocation runs as two independent processes:

- **VC allocation.** A head flit that does not yet own an output virtual channel asks for a free one.
- **Switch allocation.** Every input that owns an output virtual channel competes each cycle for the one physical output.

The sender keeps a credit counter for each downstream virtual channel. A flit is sent only when the receiver is known to have room for it. A credit return adds the slot back.

Grants are combinational in the cycle of the request. All ownership, busy and credit state changes at the next clock edge. Both allocators rotate priority round-robin. An output virtual channel stays reserved until the tail flit of its packet has crossed the switch.

Top module: `vc_sw_alloc`

## Requirements
- R1: After reset no grant is given without a request, `cred_err` is 0, all output VCs are free, and every credit counter holds BUF_DEPTH (4).
- R2: A VC grant goes only to an input whose `flit_valid` and `flit_head` are both 1 and that owns no output VC. The grant appears in the same cycle. A valid non-head flit on an input without a VC gets neither grant.
- R3: At most one VC grant is given per cycle. Requesting inputs are served round-robin: after input i wins, input i+1 has top priority. Priority does not move in a cycle when no output VC is free.
- R4: The output VC handed out is chosen round-robin among the free ones, starting at VC 0 after reset. Its index appears on `vca_vc`.
- R5: An output VC stays reserved from its allocation until the cycle after the switch grant of a flit with `flit_tail` = 1. While every output VC is reserved, head requests get no VC grant.
- R6: An input may take part in switch allocation only if:
  - its flit is valid,
  - it owns an output VC, and
  - that VC's credit count is nonzero.
  
  At most one switch grant is given per cycle, in the request cycle. `sa_vc` carries the index of the winner's owned VC.
- R7: Eligible inputs win the switch in round-robin order: after input i wins, input i+1 has top priority.
- R8: Each switch grant lowers its VC's credit count by 1, and each credit return (`cred_valid` with index `cred_vc`) raises it by 1. A VC at zero credits gets no switch grant until a return arrives.
- R9: A credit return to a VC whose count already equals BUF_DEPTH leaves the count unchanged. It sets `cred_err` from the next cycle until reset.
- R10: A switch grant and a credit return on the same VC in the same cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_valid | input | NUM_IN | Input VC i has a flit routed to this output |
| flit_head | input | NUM_IN | The waiting flit is a packet head |
| flit_tail | input | NUM_IN | The waiting flit is a packet tail |
| cred_valid | input | 1 | A credit is returned this cycle |
| cred_vc | input | clog2(NUM_VC) | Output VC the credit belongs to |
| vca_gnt | output | NUM_IN | One-hot VC allocation grant |
| vca_vc | output | clog2(NUM_VC) | Output VC assigned by `vca_gnt` |
| sa_gnt | output | NUM_IN | One-hot switch grant |
| sa_vc | output | clog2(NUM_VC) | Output VC of the flit granted the switch |
| cred_err | output | 1 | Sticky flag: credit returned to a full counter |

## Verification
The bench opens with three simultaneous head requests. This separates round-robin order over inputs from rotation over free VCs, and it shows that a head cannot reach the switch until the cycle after its VC grant.

A single input then drains its VC to zero credits and is refilled one credit at a time. This shows that the credit gate, the decrement and the increment each act on the right cycle.

More head requests than free VCs are then raised. This shows that a reserved VC is withheld until the cycle after its tail crosses the switch, and that priority does not drift while no VC is free.

A grant that coincides with a return, followed by two returns to a nearly full counter, separates the cancel case from the overflow case. After the overflow, the number of sends still allowed shows that the counter stayed capped.

// File: rtl/vcsa_pkg.sv
package vcsa_pkg;
    // Default sizing shared by the allocator and its bench
    localparam int DEF_NUM_IN    = 5;
    localparam int DEF_NUM_VC    = 4;
    localparam int DEF_BUF_DEPTH = 4;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_d, ptr_q;
    logic [IW-1:0] win_idx;
    logic          found;

    // Search from the pointer, wrapping once around
    always_comb begin
        int idx;
        gnt     = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!found && req[idx]) begin
                found        = 1'b1;
                gnt[idx]     = 1'b1;
                win_idx      = IW'(idx);
            end
        end
        ptr_d = ptr_q;
        if (adv && found) begin
            ptr_d = (win_idx == IW'(N - 1)) ? '0 : win_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R3
    rr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7
    rr_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |gnt |-> |(gnt & req));
endmodule

// File: rtl/credit_cell.sv
module credit_cell #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail,
    output logic ovf
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        ovf   = 1'b0;
        case ({take, give})
            2'b10: cnt_d = cnt_q - 1'b1;
            2'b01: begin
                if (cnt_q == CW'(DEPTH)) ovf   = 1'b1;
                else                     cnt_d = cnt_q + 1'b1;
            end
            default: cnt_d = cnt_q;
        endcase
    end

    assign avail = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(DEPTH);
        else        cnt_q <= cnt_d;
    end

    // R8
    take_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt_q != '0));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R10
    cancel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> $stable(cnt_q));
endmodule

// File: rtl/vc_sw_alloc.sv
module vc_sw_alloc
    import vcsa_pkg::*;
#(
    parameter int NUM_IN    = DEF_NUM_IN,
    parameter int NUM_VC    = DEF_NUM_VC,
    parameter int BUF_DEPTH = DEF_BUF_DEPTH,
    localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] flit_valid,
    input  logic [NUM_IN-1:0] flit_head,
    input  logic [NUM_IN-1:0] flit_tail,
    input  logic              cred_valid,
    input  logic [VW-1:0]     cred_vc,
    output logic [NUM_IN-1:0] vca_gnt,
    output logic [VW-1:0]     vca_vc,
    output logic [NUM_IN-1:0] sa_gnt,
    output logic [VW-1:0]     sa_vc,
    output logic              cred_err
);
    typedef struct packed {
        logic [NUM_IN-1:0]          held;
        logic [NUM_IN-1:0][VW-1:0]  owned;
        logic [NUM_VC-1:0]          busy;
        logic                       err;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_IN-1:0] va_req, in_gnt, sa_elig;
    logic [NUM_VC-1:0] vc_free, vc_gnt, vc_avail, vc_take, vc_give, vc_ovf;
    logic              any_free, va_any, sa_any;
    logic [IW-1:0]     va_win, sa_win;
    logic [VW-1:0]     vc_win;

    // ---------------- VC allocation ----------------
    assign vc_free  = ~st_q.busy;
    assign any_free = |vc_free;
    assign va_req   = flit_valid & flit_head & ~st_q.held & {NUM_IN{any_free}};

    rr_pick #(.N(NUM_IN)) u_in_arb (
        .clk(clk), .rst_n(rst_n), .req(va_req), .adv(any_free), .gnt(in_gnt)
    );

    assign va_any = |in_gnt;

    rr_pick #(.N(NUM_VC)) u_vc_arb (
        .clk(clk), .rst_n(rst_n), .req(vc_free), .adv(va_any), .gnt(vc_gnt)
    );

    always_comb begin
        va_win = '0;
        for (int i = 0; i < NUM_IN; i++) if (in_gnt[i]) va_win = IW'(i);
        vc_win = '0;
        for (int v = 0; v < NUM_VC; v++) if (vc_gnt[v]) vc_win = VW'(v);
    end

    assign vca_gnt = in_gnt;
    assign vca_vc  = vc_win;

    // ---------------- Switch allocation ----------------
    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            sa_elig[i] = flit_valid[i] && st_q.held[i] && vc_avail[st_q.owned[i]];
        end
    end

    rr_pick #(.N(NUM_IN)) u_sw_arb (
        .clk(clk), .rst_n(rst_n), .req(sa_elig), .adv(1'b1), .gnt(sa_gnt)
    );

    assign sa_any = |sa_gnt;

    always_comb begin
        sa_win = '0;
        for (int i = 0; i < NUM_IN; i++) if (sa_gnt[i]) sa_win = IW'(i);
    end

    assign sa_vc = st_q.owned[sa_win];

    // ---------------- Credit bank ----------------
    for (genvar v = 0; v < NUM_VC; v++) begin : g_cred
        assign vc_take[v] = sa_any && (sa_vc == VW'(v));
        assign vc_give[v] = cred_valid && (cred_vc == VW'(v));
        credit_cell #(.DEPTH(BUF_DEPTH)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .take(vc_take[v]), .give(vc_give[v]),
            .avail(vc_avail[v]), .ovf(vc_ovf[v])
        );
    end

    // ---------------- State update ----------------
    always_comb begin
        st_d = st_q;
        if (va_any) begin
            st_d.held[va_win]  = 1'b1;
            st_d.owned[va_win] = vc_win;
            st_d.busy[vc_win]  = 1'b1;
        end
        if (sa_any && flit_tail[sa_win]) begin
            st_d.held[sa_win] = 1'b0;
            st_d.busy[sa_vc]  = 1'b0;
        end
        if (|vc_ovf) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cred_err = st_q.err;

    // R2
    vca_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |vca_gnt |-> |(vca_gnt & flit_valid & flit_head));

    // R5
    vca_free_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |vca_gnt |-> !st_q.busy[vca_vc]);

    // R6
    sa_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_gnt));

    // R6
    sa_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |sa_gnt |-> |(sa_gnt & st_q.held & flit_valid));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cred_err |=> cred_err);
endmodule

// File: tb/vc_sw_alloc_test.sv
`timescale 1ns/1ps
module vc_sw_alloc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] flit_valid = '0, flit_head = '0, flit_tail = '0;
    logic       cred_valid = 1'b0;
    logic [1:0] cred_vc = '0;
    logic [4:0] vca_gnt, sa_gnt;
    logic [1:0] vca_vc, sa_vc;
    logic       cred_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic       va;
        logic [2:0] vai;
        logic [1:0] vav;
        logic       sa;
        logic [2:0] sai;
        logic [1:0] sav;
        logic       err;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    always #5 clk = ~clk;

    vc_sw_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .flit_valid(flit_valid), .flit_head(flit_head), .flit_tail(flit_tail),
        .cred_valid(cred_valid), .cred_vc(cred_vc),
        .vca_gnt(vca_gnt), .vca_vc(vca_vc),
        .sa_gnt(sa_gnt), .sa_vc(sa_vc), .cred_err(cred_err)
    );

    function automatic exp_t mk(input logic va, input int vai, input int vav,
                                input logic sa, input int sai, input int sav,
                                input logic err);
        exp_t e;
        e.va = va;  e.vai = 3'(vai); e.vav = 2'(vav);
        e.sa = sa;  e.sai = 3'(sai); e.sav = 2'(sav);
        e.err = err;
        return e;
    endfunction

    // Driver: one cycle of stimulus plus its expected outcome
    task automatic cyc(input logic [4:0] v, input logic [4:0] h, input logic [4:0] t,
                       input logic cv, input logic [1:0] cvc,
                       input exp_t e, input string tag);
        @(negedge clk);
        flit_valid = v; flit_head = h; flit_tail = t;
        cred_valid = cv; cred_vc = cvc;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: compare outputs away from the rising edge
    always @(negedge clk) begin
        #2;
        if (expq.size() > 0) begin
            exp_t  e;
            string tg;
            logic [4:0] ev, es;
            e  = expq.pop_front();
            tg = tagq.pop_front();
            ev = e.va ? (5'b1 << e.vai) : 5'b0;
            es = e.sa ? (5'b1 << e.sai) : 5'b0;
            checks++;
            if (vca_gnt !== ev || (e.va && vca_vc !== e.vav)) begin
                errors++;
                $display("FAIL %s vc grant: got gnt=%b vc=%0d, expected gnt=%b vc=%0d",
                         tg, vca_gnt, vca_vc, ev, e.vav);
            end
            checks++;
            if (sa_gnt !== es || (e.sa && sa_vc !== e.sav)) begin
                errors++;
                $display("FAIL %s switch grant: got gnt=%b vc=%0d, expected gnt=%b vc=%0d",
                         tg, sa_gnt, sa_vc, es, e.sav);
            end
            checks++;
            if (cred_err !== e.err) begin
                errors++;
                $display("FAIL %s error flag: got %b, expected %b", tg, cred_err, e.err);
            end
        end
    end

    exp_t none0;

    initial begin
        none0 = mk(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        cyc(5'b00000, 5'b00000, 5'b0, 0, 0, none0, "R1");
        // R3 R4: three heads at once, inputs and VCs rotate
        cyc(5'b00111, 5'b00111, 5'b0, 0, 0, mk(1, 0, 0, 0, 0, 0, 0), "R3");
        cyc(5'b00111, 5'b00111, 5'b0, 0, 0, mk(1, 1, 1, 1, 0, 0, 0), "R4");
        cyc(5'b00111, 5'b00110, 5'b0, 0, 0, mk(1, 2, 2, 1, 1, 1, 0), "R7");
        cyc(5'b00111, 5'b00100, 5'b0, 0, 0, mk(0, 0, 0, 1, 2, 2, 0), "R7");
        cyc(5'b00111, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 0, 0, 0), "R7");
        // R8: drain VC0 credits
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 0, 0, 0), "R8");
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 0, 0, 0), "R8");
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, none0, "R8");
        cyc(5'b00001, 5'b00000, 5'b0, 1, 2'd0, none0, "R8");
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 0, 0, 0), "R8");
        cyc(5'b00001, 5'b00000, 5'b00001, 1, 2'd0, none0, "R8");
        cyc(5'b00001, 5'b00000, 5'b00001, 0, 0, mk(0, 0, 0, 1, 0, 0, 0), "R6");
        // R5: more heads than free VCs
        cyc(5'b11001, 5'b11001, 5'b0, 0, 0, mk(1, 3, 3, 0, 0, 0, 0), "R5");
        cyc(5'b11001, 5'b11001, 5'b0, 0, 0, mk(1, 4, 0, 1, 3, 3, 0), "R5");
        cyc(5'b11001, 5'b10001, 5'b0, 0, 0, mk(0, 0, 0, 1, 3, 3, 0), "R5");
        cyc(5'b11001, 5'b10001, 5'b01000, 0, 0, mk(0, 0, 0, 1, 3, 3, 0), "R5");
        cyc(5'b10001, 5'b10001, 5'b0, 0, 0, mk(1, 0, 3, 0, 0, 0, 0), "R5");
        // R10: grant and return on VC3 together
        cyc(5'b00001, 5'b00001, 5'b0, 1, 2'd3, mk(0, 0, 0, 1, 0, 3, 0), "R10");
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 0, 3, 0), "R10");
        cyc(5'b00001, 5'b00000, 5'b0, 0, 0, none0, "R10");
        // R9: overflow of VC1
        cyc(5'b00000, 5'b00000, 5'b0, 1, 2'd1, none0, "R9");
        cyc(5'b00000, 5'b00000, 5'b0, 1, 2'd1, none0, "R9");
        cyc(5'b00010, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 1, 1, 1), "R9");
        cyc(5'b00010, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 1, 1, 1), "R9");
        cyc(5'b00010, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 1, 1, 1), "R9");
        cyc(5'b00010, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 1, 1, 1, 1), "R9");
        cyc(5'b00010, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 0, 0, 0, 1), "R9");
        // R2: valid body flit on an input without a VC
        cyc(5'b01000, 5'b00000, 5'b0, 0, 0, mk(0, 0, 0, 0, 0, 0, 1), "R2");
        @(negedge clk);
        flit_valid = '0; flit_head = '0; flit_tail = '0; cred_valid = 1'b0;
        #4;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule